// File: doc/BRIEF.md
# Multi-mode timer with watchdog option

This block holds three 16-bit down-counters behind a small register port. Each counter advances only on cycles where the prescaled `tick` enable is high. A counter either runs once to zero and halts, or reloads itself from its load value and keeps going. Every transition of a counter into zero produces a single-cycle interrupt pulse on that timer's own line.

Timer 0 has an extra watchdog personality. Once software switches it on, it cannot be switched off again. Software keeps it alive by rewriting its load register. If it ever reaches zero, the block raises a reset request toward the subsystem, and that request stays up until the block itself is reset. Timers 1 and 2 are general purpose only.

Top module: `multi_timer`

## Requirements
- R1: Timer i owns three registers: address 4*i holds the load value, 4*i+1 the current count, and 4*i+2 the control word. Every other address reads zero. After reset, every register reads zero and all outputs are low.
- R2: The control word has three bits. Bit 0 is run. Bit 1 selects the mode: 1 means auto-reload, 0 means stop at zero. Bit 2 enables the watchdog; it exists on timer 0 only and always reads 0 on timers 1 and 2. When a control write and a tick fall in the same cycle, the written bits win.
- R3: A running timer with a nonzero count decrements by exactly one on each cycle with `tick` high. Without `tick`, the count does not change.
- R4: In stop-at-zero mode, the run bit clears on the tick that brings the count to zero, and the count then stays at zero. A running timer already at zero clears its run bit on the next tick and raises no interrupt.
- R5: In auto-reload mode, a tick that finds the count at zero copies the load value into the count, and counting continues.
- R6: `irq[i]` is high for exactly one cycle, on the clock edge at which timer i's count goes from 1 to 0.
- R7: With the watchdog enabled, timer 0 reaching zero raises `rst_req` on the same edge as `irq[0]`. In this mode the count then stays at zero.
- R8: Once raised, `rst_req` stays high until `rst_n` is asserted.
- R9: Setting control bit 2 on timer 0 forces run on. From then until reset, control writes to timer 0 are ignored.
- R10: A write to a load register always updates the load value. It also copies into the count when that timer is stopped, or when it is in watchdog mode (this is the watchdog reload). Such a write overrides a tick in the same cycle. Writes to a count address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 3 | Per-timer zero-crossing pulse |
| rst_req | output | 1 | Sticky watchdog reset request |

## Verification
The bench first drives directed cases:
- A one-shot run that stops exactly at zero.
- An auto-reload sequence, including the zero-to-load step. A design that reloaded on the 1-to-0 tick would skip the zero state and shift every later interrupt.
- An attempt to disable the watchdog after it has been enabled. A lock that leaked would let a runaway program silence it.
- A watchdog reload that lands on a tick, which must win. Otherwise the watchdog would fire one count early.
- Writes to count addresses and to the watchdog bit of timers 1 and 2. A design that got these wrong would corrupt counts or reset the subsystem from the wrong timer.

After the directed cases, seeded random writes and ticks compare every interrupt and every register against a reference model. This exercises simultaneous writes and ticks.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    // Control word bit positions
    localparam int CTL_RUN  = 0;
    localparam int CTL_AUTO = 1;
    localparam int CTL_WDOG = 2;

    // Register selector within one timer's 4-word window
    typedef enum logic [1:0] {
        SEL_LOAD  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic autold;
        logic wdog;
    } chan_flags_t;

endpackage

// File: rtl/timer_chan.sv
module timer_chan
    import mtimer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit HAS_WDOG = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_load,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] count_o,
    output chan_flags_t      flags_o,
    output logic             irq_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] count;
        chan_flags_t      f;
        logic             irq;
        logic             expired;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     kick;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        // a load write copies into the count when stopped or when guarding
        kick = wr_load && (!st_q.f.run || st_q.f.wdog);

        if (tick && st_q.f.run && !kick) begin
            if (st_q.count != '0) begin
                st_d.count = st_q.count - 1'b1;
                if (st_q.count == CNT_W'(1)) begin
                    st_d.irq = 1'b1;
                    if (!st_q.f.autold && !st_q.f.wdog) begin
                        st_d.f.run = 1'b0;
                    end
                    if (HAS_WDOG && st_q.f.wdog) begin
                        st_d.expired = 1'b1;
                    end
                end
            end else if (st_q.f.wdog) begin
                st_d.count = '0;
            end else if (st_q.f.autold) begin
                st_d.count = st_q.load;
            end else begin
                st_d.f.run = 1'b0;
            end
        end

        if (wr_ctrl && !st_q.f.wdog) begin
            st_d.f.run    = wdata[CTL_RUN];
            st_d.f.autold = wdata[CTL_AUTO];
            if (HAS_WDOG && wdata[CTL_WDOG]) begin
                st_d.f.wdog = 1'b1;
                st_d.f.run  = 1'b1;
            end
        end

        if (wr_load) begin
            st_d.load = wdata;
            if (kick) begin
                st_d.count = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o   = st_q.load;
    assign count_o  = st_q.count;
    assign flags_o  = st_q.f;
    assign irq_o    = st_q.irq;
    assign expire_o = st_q.expired;

endmodule

// File: rtl/timer_rdmux.sv
module timer_rdmux
    import mtimer_pkg::*;
#(
    parameter int NUM    = 3,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM-1:0][CNT_W-1:0]   load_all,
    input  logic [NUM-1:0][CNT_W-1:0]   count_all,
    input  chan_flags_t [NUM-1:0]       flags_all,
    output logic [CNT_W-1:0]            rdata
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    reg_sel_e         sel;

    always_comb begin
        idx   = addr[ADDR_W-1:2];
        sel   = reg_sel_e'(addr[1:0]);
        rdata = '0;
        for (int i = 0; i < NUM; i++) begin
            if (idx == IDX_W'(i)) begin
                unique case (sel)
                    SEL_LOAD:  rdata = load_all[i];
                    SEL_COUNT: rdata = count_all[i];
                    SEL_CTRL: begin
                        rdata[CTL_RUN]  = flags_all[i].run;
                        rdata[CTL_AUTO] = flags_all[i].autold;
                        rdata[CTL_WDOG] = flags_all[i].wdog;
                    end
                    SEL_NONE:  rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/multi_timer.sv
module multi_timer
    import mtimer_pkg::*;
#(
    parameter  int NUM_TIMERS = 3,
    parameter  int CNT_W      = 16,
    localparam int ADDR_W     = $clog2(NUM_TIMERS * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_TIMERS-1:0] irq,
    output logic              rst_req
);

    logic [NUM_TIMERS-1:0][CNT_W-1:0] load_all;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] count_all;
    chan_flags_t [NUM_TIMERS-1:0]     flags_all;
    logic [NUM_TIMERS-1:0]            expire_all;

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * i);
        logic wr_load, wr_ctrl;

        assign wr_load = bus_we && (bus_addr == (BASE | ADDR_W'(SEL_LOAD)));
        assign wr_ctrl = bus_we && (bus_addr == (BASE | ADDR_W'(SEL_CTRL)));

        timer_chan #(
            .CNT_W    (CNT_W),
            .HAS_WDOG (i == 0)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wr_load  (wr_load),
            .wr_ctrl  (wr_ctrl),
            .wdata    (bus_wdata),
            .load_o   (load_all[i]),
            .count_o  (count_all[i]),
            .flags_o  (flags_all[i]),
            .irq_o    (irq[i]),
            .expire_o (expire_all[i])
        );
    end

    timer_rdmux #(
        .NUM    (NUM_TIMERS),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_rdmux (
        .addr      (bus_addr),
        .load_all  (load_all),
        .count_all (count_all),
        .flags_all (flags_all),
        .rdata     (bus_rdata)
    );

    // only timer 0 can expire; the others tie their flag low
    assign rst_req = |expire_all;

endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
    parameter int NUM = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick,
    input logic [NUM-1:0] irq,
    input logic           rst_req,
    input logic           wdog0,
    input logic           run0
);

    for (genvar i = 0; i < NUM; i++) begin : g_irq
        assert_irq_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> $past(tick));
        assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |=> !irq[i]);
    end

    assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> irq[0]);

    assert_rst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    assert_wdog_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdog0 |=> (wdog0 && run0));

endmodule

bind multi_timer timer_chk #(.NUM(NUM_TIMERS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .irq     (irq),
    .rst_req (rst_req),
    .wdog0   (flags_all[0].wdog),
    .run0    (flags_all[0].run)
);

// File: tb/sim_multi_timer.sv
`timescale 1ns/1ps
module sim_multi_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  irq;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [15:0] m_load [3];
    logic [15:0] m_cnt  [3];
    bit m_run [3];
    bit m_auto[3];
    bit m_wd  [3];
    bit m_irq [3];
    bit m_exp;

    multi_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            m_load[i] = '0; m_cnt[i] = '0; m_run[i] = 0;
            m_auto[i] = 0; m_wd[i] = 0; m_irq[i] = 0;
        end
        m_exp = 0;
    endtask

    function automatic logic [15:0] model_read(input logic [3:0] a);
        int i = int'(a[3:2]);
        if (i > 2) return '0;
        case (a[1:0])
            2'd0: return m_load[i];
            2'd1: return m_cnt[i];
            2'd2: return {13'd0, m_wd[i], m_auto[i], m_run[i]};
            default: return '0;
        endcase
    endfunction

    task automatic model_step(input bit we, input logic [3:0] a, input logic [15:0] dat, input bit tk);
        for (int i = 0; i < 3; i++) begin
            bit wl = we && (int'(a[3:2]) == i) && (a[1:0] == 2'd0);
            bit wc = we && (int'(a[3:2]) == i) && (a[1:0] == 2'd2);
            bit kick = wl && (!m_run[i] || m_wd[i]);
            bit run_n = m_run[i];
            logic [15:0] cnt_n = m_cnt[i];
            m_irq[i] = 0;
            if (tk && m_run[i] && !kick) begin
                if (m_cnt[i] != 0) begin
                    cnt_n = m_cnt[i] - 1;
                    if (m_cnt[i] == 1) begin
                        m_irq[i] = 1;
                        if (!m_auto[i] && !m_wd[i]) run_n = 0;
                        if (m_wd[i]) m_exp = 1;
                    end
                end else if (m_wd[i]) begin
                    cnt_n = 0;
                end else if (m_auto[i]) begin
                    cnt_n = m_load[i];
                end else begin
                    run_n = 0;
                end
            end
            if (wc && !m_wd[i]) begin
                run_n = dat[0];
                m_auto[i] = dat[1];
                if (i == 0 && dat[2]) begin m_wd[i] = 1; run_n = 1; end
            end
            if (wl) begin
                m_load[i] = dat;
                if (kick) cnt_n = dat;
            end
            m_run[i] = run_n;
            m_cnt[i] = cnt_n;
        end
    endtask

    task automatic cyc(input bit we, input logic [3:0] a, input logic [15:0] dat, input bit tk);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = dat; tick = tk;
        model_step(we, a, dat, tk);
        @(posedge clk); #1;
        check("R6 irq", {13'd0, irq}, {13'd0, m_irq[2], m_irq[1], m_irq[0]});
        check("R8 rst_req", {15'd0, rst_req}, {15'd0, m_exp});
    endtask

    task automatic rd(input logic [3:0] a, input string req);
        @(negedge clk);
        bus_we = 0; tick = 0; bus_addr = a;
        for (int i = 0; i < 3; i++) m_irq[i] = 0;
        #1;
        check(req, bus_rdata, model_read(a));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bus_we = 0; tick = 0;
        repeat (2) @(posedge clk);
        #1; rst_n = 1;
        model_reset();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        do_reset();

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            @(negedge clk); bus_addr = 4'(a); #1;
            check("R1 reset read", bus_rdata, 16'h0000);
        end
        check("R1 irq reset", {13'd0, irq}, 16'h0000);
        check("R1 rst_req reset", {15'd0, rst_req}, 16'h0000);

        // R4 one-shot on timer 1
        cyc(1, 4'd4, 16'd3, 0);
        @(negedge clk); bus_we = 0; bus_addr = 4'd5; #1;
        check("R10 load copies count", bus_rdata, 16'd3);
        cyc(1, 4'd6, 16'h0001, 0);
        cyc(0, 4'd0, 0, 1);
        cyc(0, 4'd0, 0, 0);
        rd(4'd5, "R3 hold without tick");
        check("R3 count after one tick", bus_rdata, 16'd2);
        cyc(0, 4'd0, 0, 1);
        cyc(0, 4'd0, 0, 1);
        check("R6 timer1 pulse", {13'd0, irq}, 16'h0002);
        cyc(0, 4'd0, 0, 1);
        check("R6 pulse ends", {13'd0, irq}, 16'h0000);
        rd(4'd6, "R4 run cleared");
        check("R4 ctrl after stop", bus_rdata, 16'h0000);
        cyc(1, 4'd5, 16'd9, 0);
        rd(4'd5, "R10 count write ignored");

        // R5 auto-reload on timer 2
        cyc(1, 4'd8, 16'd2, 0);
        cyc(1, 4'd10, 16'h0003, 0);
        cyc(0, 4'd0, 0, 1);
        cyc(0, 4'd0, 0, 1);
        check("R6 timer2 first pulse", {13'd0, irq}, 16'h0004);
        cyc(0, 4'd0, 0, 1);
        rd(4'd9, "R5 reload");
        check("R5 reloaded value", bus_rdata, 16'd2);
        cyc(1, 4'd8, 16'd5, 0);
        rd(4'd9, "R10 running load keeps count");
        check("R10 count kept", bus_rdata, 16'd2);
        cyc(0, 4'd0, 0, 1);
        cyc(0, 4'd0, 0, 1);
        check("R5 second pulse", {13'd0, irq}, 16'h0004);
        cyc(1, 4'd10, 16'h0000, 0);

        // R2 watchdog bit absent on timer 1
        cyc(1, 4'd6, 16'h0004, 0);
        rd(4'd6, "R2 no wdog on timer1");
        check("R2 timer1 ctrl", bus_rdata, 16'h0000);

        // R9 watchdog on timer 0
        cyc(1, 4'd0, 16'd3, 0);
        cyc(1, 4'd2, 16'h0004, 0);
        rd(4'd2, "R9 wdog forces run");
        check("R9 ctrl value", bus_rdata, 16'h0005);
        cyc(1, 4'd2, 16'h0000, 1);
        rd(4'd2, "R9 disable ignored");
        check("R9 ctrl locked", bus_rdata, 16'h0005);
        cyc(0, 4'd0, 0, 1);
        cyc(1, 4'd0, 16'd3, 1);
        rd(4'd1, "R10 kick over tick");
        check("R10 kicked count", bus_rdata, 16'd3);
        cyc(0, 4'd0, 0, 1);
        cyc(0, 4'd0, 0, 1);
        check("R7 no early expiry", {15'd0, rst_req}, 16'h0000);
        cyc(0, 4'd0, 0, 1);
        check("R7 rst_req with irq0", {12'd0, irq, rst_req}, 16'h0003);
        for (int k = 0; k < 5; k++) cyc(0, 4'd0, 0, k[0]);
        check("R8 rst_req held", {15'd0, rst_req}, 16'h0001);
        rd(4'd1, "R7 count stays zero");
        do_reset();
        check("R8 cleared by reset", {15'd0, rst_req}, 16'h0000);

        // seeded random phase
        for (int n = 0; n < 4000; n++) begin
            bit we = ($urandom % 4) == 0;
            logic [3:0] a = 4'($urandom % 16);
            logic [15:0] d = (a[1:0] == 2'd2) ? 16'($urandom % 8) : 16'($urandom % 6);
            if (a == 4'd2 && d[2] && ($urandom % 8) != 0) d[2] = 1'b0;
            cyc(we, a, d, ($urandom % 2) == 1);
            if (n % 32 == 31) begin
                for (int r = 0; r < 12; r++) rd(4'(r), "R1 random register");
            end
            if (n == 2000) do_reset();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule